// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Code Register Bank

This block holds the digital codes for four DAC channels behind a byte-wide register bus. Each channel has two storage levels. A staged level takes bus writes. An active level drives the DAC code outputs. Software can prepare new codes for every channel, and all four outputs change together on a single transfer event.

The transfer event has two possible sources, and a mode bit picks one of them. In pin mode, the source is a falling edge on an active-low load pin. The pin goes through two synchroniser flops and a small edge state machine. In software mode, the source is a write to a load command bit, which clears itself.

The bank also holds one gain-select bit per channel, and these bits go to the analog stage. Reset clears every code to zero. The code resolution is a parameter from 8 to 16 bits, and the coding is straight binary.

The pin state machine has three states:
- `ST_WAIT_HIGH` is the reset state. It waits until the synchronised pin reads high, then moves to `ST_ARMED`.
- `ST_ARMED` watches for the pin to go low. If the pin goes low in pin mode, the machine moves to `ST_FIRE`. If it goes low in software mode, the machine moves back to `ST_WAIT_HIGH` and no transfer happens.
- `ST_FIRE` lasts one cycle and asserts the transfer. It always moves on to `ST_WAIT_HIGH`.

Top module: `dac_dbuf_bank`

## Requirements
- R1: After reset, all four active codes and all four gain bits are zero, software mode is off, and every register reads back zero.
- R2: Channel n's staged code sits at two byte registers.
  - The low byte is at 0x10+2n. It holds the code's bits below the top eight, left-justified in bits 7 down.
  - The high byte is at 0x11+2n. It holds the top eight code bits.
  - Unused low bits are not stored and read back as zero. At 12 bits, code 0xABC is high 0xAB and low 0xC0.
- R3: A bus write changes only the staged level. The active codes keep their value until a transfer event.
- R4: A transfer copies all four staged codes to the active codes in the same cycle.
- R5: In pin mode, a high-to-low transition of the load pin starts one transfer. The active codes change on the fourth rising clock edge after the pin falls. A pin held low gives no further transfer until it has gone high and then fallen again.
- R6: In pin mode, writing to the load register at 0x1C has no effect.
- R7: Bit 3 of register 0x1A selects software mode.
  - In software mode, pin edges are ignored.
  - Writing 1 to bit 0 of 0x1C transfers the staged codes on the second rising edge counted from the write edge.
  - The load bit reads back 0.
- R8: Bits 3..0 of register 0x1B are the per-channel gain selects. Bit n drives `gain_sel_o[n]` and reads back at the same position.
- R9: If the pin falls while software mode is on, the pin is disarmed. After a return to pin mode, no transfer happens until the pin has gone high and fallen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ldac_n_i | input | 1 | Asynchronous load pin; a falling edge starts a transfer |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| dac_code_o | output | 4*RES | Active codes, channel n at bits [n*RES +: RES] |
| gain_sel_o | output | 4 | Per-channel gain select |

## Verification
Each result is due at a fixed cycle after its stimulus, counted from the clock edge that samples it:
- Staged read-back is valid right after the write edge.
- Gain bits are valid right after the write edge.
- A software load shows on the active codes on the second rising edge.
- A pin fall shows on the active codes on the fourth rising edge, because of two synchroniser flops, the state register and the output register.

The driver tags every expected output with the cycle number at which it is due. The driver always pushes the unchanged value one cycle before the due cycle, so a transfer that arrives early or late is caught. The monitor compares on the falling edge of the tagged cycle.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
    localparam int NUM_CH = 4;
    localparam logic [7:0] ADDR_CODE_BASE = 8'h10;
    localparam logic [7:0] ADDR_MODE      = 8'h1A;
    localparam logic [7:0] ADDR_GAIN      = 8'h1B;
    localparam logic [7:0] ADDR_LOAD      = 8'h1C;
    localparam int MODE_SW_BIT = 3;
    localparam int LOAD_BIT    = 0;

    typedef enum logic [1:0] {
        ST_WAIT_HIGH = 2'd0,
        ST_ARMED     = 2'd1,
        ST_FIRE      = 2'd2
    } ldac_state_e;
endpackage

// File: rtl/ldac_edge_fsm.sv
module ldac_edge_fsm
    import dac_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ldac_n_i,
    input  logic sw_mode_i,
    output logic pin_fire_o
);
    logic        sync1_q, sync2_q;
    ldac_state_e state_q, state_d;

    // Two-flop synchroniser; resets low so a pin must be seen high first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= ldac_n_i;
            sync2_q <= sync1_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_HIGH: if (sync2_q) state_d = ST_ARMED;
            ST_ARMED:     if (!sync2_q) state_d = sw_mode_i ? ST_WAIT_HIGH : ST_FIRE;
            ST_FIRE:      state_d = ST_WAIT_HIGH;
            default:      state_d = ST_WAIT_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        pin_fire_o = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/dac_stage_regs.sv
module dac_stage_regs
    import dac_bank_pkg::*;
#(
    parameter int RES = 12,
    parameter int NCH = NUM_CH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we_i,
    input  logic [7:0]         bus_addr_i,
    input  logic [7:0]         bus_wdata_i,
    output logic [7:0]         bus_rdata_o,
    output logic [NCH*RES-1:0] staged_o,
    output logic               sw_mode_o,
    output logic [NCH-1:0]     gain_o,
    output logic               sw_fire_o
);
    localparam int         PAD      = 16 - RES;
    localparam logic [7:0] LSB_MASK = 8'((16'hFF << PAD) & 16'hFF);

    logic [7:0] lo_q [NCH];
    logic [7:0] hi_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [7:0] A_LO = 8'(int'(ADDR_CODE_BASE) + 2 * g);
        localparam logic [7:0] A_HI = 8'(int'(ADDR_CODE_BASE) + 2 * g + 1);
        logic [15:0] word;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[g] <= '0;
                hi_q[g] <= '0;
            end else if (bus_we_i) begin
                if (bus_addr_i == A_LO) lo_q[g] <= bus_wdata_i & LSB_MASK;
                if (bus_addr_i == A_HI) hi_q[g] <= bus_wdata_i;
            end
        end

        assign word = {hi_q[g], lo_q[g]};
        assign staged_o[g*RES +: RES] = word[15 -: RES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_mode_o <= 1'b0;
            gain_o    <= '0;
            sw_fire_o <= 1'b0;
        end else begin
            sw_fire_o <= bus_we_i && (bus_addr_i == ADDR_LOAD)
                         && bus_wdata_i[LOAD_BIT] && sw_mode_o;
            if (bus_we_i && bus_addr_i == ADDR_MODE) sw_mode_o <= bus_wdata_i[MODE_SW_BIT];
            if (bus_we_i && bus_addr_i == ADDR_GAIN) gain_o    <= bus_wdata_i[NCH-1:0];
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr_i == 8'(int'(ADDR_CODE_BASE) + 2 * c))     bus_rdata_o = lo_q[c];
            if (bus_addr_i == 8'(int'(ADDR_CODE_BASE) + 2 * c + 1)) bus_rdata_o = hi_q[c];
        end
        if (bus_addr_i == ADDR_MODE) bus_rdata_o[MODE_SW_BIT] = sw_mode_o;
        if (bus_addr_i == ADDR_GAIN) bus_rdata_o[NCH-1:0]     = gain_o;
    end
endmodule

// File: rtl/dac_active_regs.sv
module dac_active_regs #(
    parameter int RES = 12,
    parameter int NCH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [NCH*RES-1:0] staged_i,
    output logic [NCH*RES-1:0] code_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_act
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      code_o[g*RES +: RES] <= '0;
            else if (load_i) code_o[g*RES +: RES] <= staged_i[g*RES +: RES];
        end
    end
endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank
    import dac_bank_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ldac_n_i,
    input  logic                  bus_we_i,
    input  logic [7:0]            bus_addr_i,
    input  logic [7:0]            bus_wdata_i,
    output logic [7:0]            bus_rdata_o,
    output logic [NUM_CH*RES-1:0] dac_code_o,
    output logic [NUM_CH-1:0]     gain_sel_o
);
    localparam int NCH = NUM_CH;

    logic [NCH*RES-1:0] staged_w;
    logic               sw_mode_w;
    logic               sw_fire_w;
    logic               pin_fire_w;
    logic               xfer_w;

    dac_stage_regs #(.RES(RES), .NCH(NCH)) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .staged_o    (staged_w),
        .sw_mode_o   (sw_mode_w),
        .gain_o      (gain_sel_o),
        .sw_fire_o   (sw_fire_w)
    );

    ldac_edge_fsm u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ldac_n_i   (ldac_n_i),
        .sw_mode_i  (sw_mode_w),
        .pin_fire_o (pin_fire_w)
    );

    assign xfer_w = pin_fire_w | sw_fire_w;

    dac_active_regs #(.RES(RES), .NCH(NCH)) u_active (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (xfer_w),
        .staged_i (staged_w),
        .code_o   (dac_code_o)
    );
endmodule

// File: rtl/dac_dbuf_bank_chk.sv
module dac_dbuf_bank_chk #(
    parameter int RES = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer,
    input logic              pin_fire,
    input logic              sw_fire,
    input logic              sw_mode,
    input logic [4*RES-1:0]  staged,
    input logic [4*RES-1:0]  code,
    input logic [3:0]        gain,
    input logic              we,
    input logic [7:0]        addr,
    input logic [7:0]        wdata
);
    AST_HOLD_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(code)); // R3
    AST_XFER_COPIES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> code == $past(staged)); // R4
    AST_PIN_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fire |=> !pin_fire); // R5
    AST_SWLOAD_NEEDS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fire |-> $past(sw_mode)); // R6
    AST_PIN_NEEDS_PINMODE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fire |-> !$past(sw_mode)); // R7
    AST_GAIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 8'h1B) |=> gain == $past(wdata[3:0])); // R8
endmodule

bind dac_dbuf_bank dac_dbuf_bank_chk #(.RES(RES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer     (xfer_w),
    .pin_fire (pin_fire_w),
    .sw_fire  (sw_fire_w),
    .sw_mode  (sw_mode_w),
    .staged   (staged_w),
    .code     (dac_code_o),
    .gain     (gain_sel_o),
    .we       (bus_we_i),
    .addr     (bus_addr_i),
    .wdata    (bus_wdata_i)
);

// File: tb/dac_dbuf_bank_tb.sv
module dac_dbuf_bank_tb_top;
    localparam int RES = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ldac_n = 1'b1;
    logic            we = 1'b0;
    logic [7:0]      addr = '0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic [4*RES-1:0] code;
    logic [3:0]      gain;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        int               due;
        logic [4*RES-1:0] code;
        logic [3:0]       gain;
        string            tag;
    } exp_item_t;
    exp_item_t sb_q[$];
    exp_item_t it;

    logic [7:0]       m_lo [4];
    logic [7:0]       m_hi [4];
    logic [4*RES-1:0] m_act = '0;
    logic [3:0]       m_gain = '0;
    logic             m_sw = 1'b0;

    dac_dbuf_bank #(.RES(RES)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ldac_n_i    (ldac_n),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .dac_code_o  (code),
        .gain_sel_o  (gain)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4*RES-1:0] staged_model();
        logic [4*RES-1:0] r;
        logic [15:0] w;
        for (int c = 0; c < 4; c++) begin
            w = {m_hi[c], m_lo[c]};
            r[c*RES +: RES] = w[15 -: RES];
        end
        return r;
    endfunction

    // Monitor: compare each expected item on the falling edge of its due cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            it = sb_q.pop_front();
            n_run++;
            if (it.due < cyc) begin
                n_fail++;
                $display("FAIL %s: item missed, due %0d seen %0d", it.tag, it.due, cyc);
            end else if (code !== it.code || gain !== it.gain) begin
                n_fail++;
                $display("FAIL %s: code=%h gain=%h expected code=%h gain=%h",
                         it.tag, code, gain, it.code, it.gain);
            end
        end
    end

    task automatic push(input int due, input string tag);
        exp_item_t e;
        e.due = due; e.code = m_act; e.gain = m_gain; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        n_run++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: read %h = %h expected %h", tag, a, rdata, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        int k;
        @(negedge clk);
        k = cyc;
        we = 1'b1; addr = a; wdata = d;
        if (a >= 8'h10 && a <= 8'h17) begin
            if (a[0]) m_hi[(a - 8'h10) >> 1] = d;
            else      m_lo[(a - 8'h10) >> 1] = d & 8'hF0;
        end
        if (a == 8'h1B) m_gain = d[3:0];
        if (a == 8'h1A) m_sw = d[3];
        if (a == 8'h1C && m_sw && d[0]) begin
            push(k + 1, {tag, " old"});
            m_act = staged_model();
            push(k + 2, {tag, " new"});
        end
        @(negedge clk);
        we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pin_fall(input logic expect_load, input string tag);
        int k;
        @(negedge clk);
        k = cyc;
        ldac_n = 1'b0;
        push(k + 3, {tag, " old"});
        if (expect_load) m_act = staged_model();
        push(k + 4, {tag, " new"});
        repeat (6) @(negedge clk);
    endtask

    task automatic pin_rise();
        @(negedge clk);
        ldac_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic settle(input string tag);
        push(cyc + 2, tag);
        repeat (3) @(negedge clk);
    endtask

    task automatic load_codes(input logic [RES-1:0] c0, input logic [RES-1:0] c1,
                              input logic [RES-1:0] c2, input logic [RES-1:0] c3,
                              input string tag);
        logic [RES-1:0] cs [4];
        cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
        for (int c = 0; c < 4; c++) begin
            wr(8'(8'h11 + 2 * c), cs[c][RES-1 -: 8], tag);
            wr(8'(8'h10 + 2 * c), {cs[c][RES-9:0], 4'h0}, tag);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin m_lo[c] = '0; m_hi[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        settle("R1 reset codes and gain");
        for (int a = 8'h10; a <= 8'h1C; a++) chk_rd(8'(a), 8'h00, "R1 reset readback");

        // R2: byte layout and left-justified low bits
        wr(8'h11, 8'hAB, "R2");
        wr(8'h10, 8'hCF, "R2");
        chk_rd(8'h11, 8'hAB, "R2 high byte");
        chk_rd(8'h10, 8'hC0, "R2 low byte unused bits zero");
        // R3: active unchanged after write
        settle("R3 no transfer after write");

        load_codes(12'hABC, 12'h123, 12'hFFF, 12'h001, "R3 stage");
        settle("R3 still zero after staging");

        // R4/R5: pin fall transfers all four on the fourth edge
        pin_fall(1'b1, "R4 R5 pin fall");
        // R5: pin held low, new staged codes, no reload
        load_codes(12'h555, 12'hAAA, 12'h000, 12'h800, "R5 stage");
        repeat (10) @(negedge clk);
        settle("R5 held low no reload");
        pin_rise();
        settle("R5 rising edge no load");
        pin_fall(1'b1, "R5 second fall");
        pin_rise();

        // R6: load register ignored in pin mode
        load_codes(12'h0F0, 12'h00F, 12'hF00, 12'h777, "R6 stage");
        wr(8'h1C, 8'h01, "R6");
        settle("R6 load reg ignored in pin mode");
        chk_rd(8'h1C, 8'h00, "R6 load reg reads zero");

        // R8: gain bits
        wr(8'h1B, 8'hA5, "R8");
        settle("R8 gain output");
        chk_rd(8'h1B, 8'h05, "R8 gain readback");

        // R7: software mode
        wr(8'h1A, 8'h08, "R7 mode");
        chk_rd(8'h1A, 8'h08, "R7 mode readback");
        pin_fall(1'b0, "R7 pin ignored in sw mode");
        pin_rise();
        wr(8'h1C, 8'h01, "R7 sw load");
        chk_rd(8'h1C, 8'h00, "R7 load bit self-clears");
        load_codes(12'h321, 12'h654, 12'h987, 12'hCBA, "R7 stage");
        settle("R7 no transfer before command");
        wr(8'h1C, 8'h01, "R7 sw load 2");

        // R9: pin falls in sw mode, then return to pin mode while low
        load_codes(12'h111, 12'h222, 12'h333, 12'h444, "R9 stage");
        pin_fall(1'b0, "R9 fall in sw mode");
        wr(8'h1A, 8'h00, "R9 back to pin mode");
        repeat (6) @(negedge clk);
        settle("R9 no load while still low");
        pin_rise();
        settle("R9 rise no load");
        pin_fall(1'b1, "R9 rearmed fall");
        pin_rise();

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule